// File: doc/BRIEF.md
# Programmable Eight-Tap Fixed-Point FIR Filter

This block filters a stream of signed 16-bit samples with an eight-tap direct-form finite impulse response. Each tap weight is a signed fraction in Q1.15 form. A tap is rewritten while the filter runs: software or a sequencer presents a 3-bit tap index and a 16-bit weight, then pulses a one-cycle write strobe. The weights leave reset as a passthrough response.

A sample is taken whenever the sample strobe is high. On that clock edge three things happen. The eight-entry history shifts the new sample in. One combinational multiply-accumulate sums the eight products of weight and stored history into a 35-bit accumulator. The result register loads accumulator bits [30:15] and raises the result strobe for one cycle. The result therefore covers the eight samples taken before the current one: one sample of latency in front of the usual y = Σ h[k]·x[n−k]. That latency is what produces a step response that starts at zero.

Top module: `fir8_filter`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `res_valid` = 0 and `res_out` = 0.
- R2: After reset, tap 0 holds 0x7FFF and taps 1 to 7 hold 0. The result for a history sample s is therefore floor(s·32767/32768).
- R3: `res_valid` is high in exactly those cycles that follow a cycle with `smp_valid` high, so every sample gives exactly one one-cycle pulse.
- R4: The result issued for the sample taken at strobe m equals bits [30:15] of the 35-bit two's-complement sum of h[k]·s[m−1−k] for k = 0..7. Bits above bit 30 are dropped, so the result wraps. The shift floors toward minus infinity. Tap index k weights the sample taken k+1 strobes earlier.
- R5: A cycle with `coef_we` high writes `coef_val` into the tap chosen by `coef_idx` (0 to 7). No other tap changes.
- R6: The history shifts only on cycles with `smp_valid` high. Idle cycles of any length between samples leave the results unchanged.
- R7: A weight write leaves the sample history untouched. A write in the same cycle as a sample strobe is first used by the following sample.
- R8: With every tap at 0x1000 (1/8) after reset and a constant input of 0x4000, the first nine results are 0, 2048, 4096, …, 16384 in steps of 2048. All results after the ninth stay at 16384.
- R9: `res_out` keeps its value in every cycle that does not follow a sample strobe.
- R10: Reset clears the sample history to zero. The first result after reset is therefore 0 whatever was fed before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| coef_we | input | 1 | One-cycle weight write strobe |
| coef_idx | input | 3 | Tap index written by `coef_we` |
| coef_val | input | 16 | Signed Q1.15 weight value |
| smp_valid | input | 1 | Sample strobe |
| smp_in | input | 16 | Signed input sample |
| res_valid | output | 1 | One-cycle result strobe |
| res_out | output | 16 | Signed filtered result |

## Verification
The bench runs the step sequence and checks that the first result is zero. A design that put the current sample into the sum would give 2048 first. Full-scale weights and samples, at both signs, drive the accumulator past bit 30; a design that saturated, rounded or used a narrow sum would differ from the wrapped value the bench expects. Weight writes land during idle gaps and in the same cycle as a sample strobe. A design that shifted the history on a write, or applied the new weight one sample early, would give a wrong next result. A reset in the middle of the stream must clear the history and bring back the passthrough weights. Random samples, weights and gaps from a fixed seed fill the rest of the run.

// File: rtl/fir8_pkg.sv
package fir8_pkg;

    parameter int TAPS = 8;
    parameter int DW   = 16;
    parameter int CW   = 16;
    parameter int FRAC = 15;

    localparam int IDXW = $clog2(TAPS);
    localparam int ACCW = DW + CW + $clog2(TAPS);

    typedef logic signed [DW-1:0]   sample_t;
    typedef logic signed [CW-1:0]   coef_t;
    typedef logic signed [ACCW-1:0] acc_t;

    typedef sample_t [TAPS-1:0] sample_vec_t;
    typedef coef_t   [TAPS-1:0] coef_vec_t;

    typedef struct packed {
        logic            en;
        logic [IDXW-1:0] idx;
        coef_t           val;
    } coef_wr_t;

    // Largest positive Q1.15 value on tap 0, zero elsewhere.
    function automatic coef_t coef_reset(input int k);
        coef_t v;
        v = '0;
        if (k == 0) begin
            v = {1'b0, {(CW-1){1'b1}}};
        end
        return v;
    endfunction

    // Drop the fractional bits and keep one sample width above them.
    function automatic sample_t q_trunc(input acc_t a);
        return a[FRAC+DW-1:FRAC];
    endfunction

endpackage

// File: rtl/fir8_coef_bank.sv
module fir8_coef_bank
    import fir8_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  coef_wr_t  wr,
    output coef_vec_t coefs
);

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        always_ff @(posedge clk) begin
            if (rst) begin
                coefs[k] <= coef_reset(k);
            end else if (wr.en && (wr.idx == IDXW'(k))) begin
                coefs[k] <= wr.val;
            end
        end
    end

endmodule

// File: rtl/fir8_delay_line.sv
module fir8_delay_line
    import fir8_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        shift,
    input  sample_t     din,
    output sample_vec_t hist
);

    for (genvar k = 0; k < TAPS; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                hist[k] <= '0;
            end else if (shift) begin
                if (k == 0) begin
                    hist[k] <= din;
                end else begin
                    hist[k] <= hist[k-1];
                end
            end
        end
    end

endmodule

// File: rtl/fir8_mac.sv
module fir8_mac
    import fir8_pkg::*;
(
    input  sample_vec_t hist,
    input  coef_vec_t   coefs,
    output acc_t        acc
);

    acc_t prod [TAPS];

    for (genvar k = 0; k < TAPS; k++) begin : g_prod
        always_comb begin
            prod[k] = acc_t'($signed(hist[k])) * acc_t'($signed(coefs[k]));
        end
    end

    always_comb begin
        acc = '0;
        for (int k = 0; k < TAPS; k++) begin
            acc = acc + prod[k];
        end
    end

endmodule

// File: rtl/fir8_filter.sv
module fir8_filter
    import fir8_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            coef_we,
    input  logic [IDXW-1:0] coef_idx,
    input  logic [CW-1:0]   coef_val,
    input  logic            smp_valid,
    input  logic [DW-1:0]   smp_in,
    output logic            res_valid,
    output logic [DW-1:0]   res_out
);

    coef_wr_t    wr;
    coef_vec_t   coefs;
    sample_vec_t hist;
    acc_t        acc;

    always_comb begin
        wr.en  = coef_we;
        wr.idx = coef_idx;
        wr.val = coef_t'(coef_val);
    end

    fir8_coef_bank i_bank (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr),
        .coefs (coefs)
    );

    fir8_delay_line i_line (
        .clk   (clk),
        .rst   (rst),
        .shift (smp_valid),
        .din   (sample_t'(smp_in)),
        .hist  (hist)
    );

    fir8_mac i_mac (
        .hist  (hist),
        .coefs (coefs),
        .acc   (acc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_out   <= '0;
        end else begin
            res_valid <= smp_valid;
            if (smp_valid) begin
                res_out <= q_trunc(acc);
            end
        end
    end

endmodule

// File: rtl/fir8_filter_chk.sv
module fir8_filter_chk
    import fir8_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          smp_valid,
    input logic          res_valid,
    input logic [DW-1:0] res_out,
    input acc_t          acc
);

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (!res_valid && res_out == '0));

    // R3
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> res_valid);

    // R3
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> !res_valid);

    // R9
    hold_out_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(res_out));

    // R4
    trunc_window_chk: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> (res_out == $past(acc[FRAC+DW-1:FRAC])));

endmodule

bind fir8_filter fir8_filter_chk i_fir8_filter_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .res_valid (res_valid),
    .res_out   (res_out),
    .acc       (acc)
);

// File: tb/test_fir8_filter.sv
`timescale 1ns/1ps
module test_fir8_filter;

    logic        clk = 1'b0;
    logic        rst;
    logic        coef_we;
    logic [2:0]  coef_idx;
    logic [15:0] coef_val;
    logic        smp_valid;
    logic [15:0] smp_in;
    logic        res_valid;
    logic [15:0] res_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic signed [15:0] m_coef [8];
    logic signed [15:0] m_hist [8];
    logic [15:0]        m_last;

    always #2.5 clk = ~clk;

    fir8_filter i_fir8_filter (
        .clk       (clk),
        .rst       (rst),
        .coef_we   (coef_we),
        .coef_idx  (coef_idx),
        .coef_val  (coef_val),
        .smp_valid (smp_valid),
        .smp_in    (smp_in),
        .res_valid (res_valid),
        .res_out   (res_out)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model_result();
        longint acc = 0;
        for (int k = 0; k < 8; k++) begin
            acc = acc + longint'(m_coef[k]) * longint'(m_hist[k]);
        end
        return acc[30:15];
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 8; k++) begin
            m_coef[k] = (k == 0) ? 16'sh7FFF : 16'sh0000;
            m_hist[k] = '0;
        end
        m_last = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1; coef_we = 1'b0; smp_valid = 1'b0;
        coef_idx = '0; coef_val = '0; smp_in = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
        // R1: reset state
        check(res_valid == 1'b0, "R1 res_valid", res_valid, 0);
        check(res_out == 16'h0, "R1 res_out", res_out, 0);
    endtask

    // One cycle: drive at a falling edge, check at the next falling edge.
    task automatic cycle(input bit v, input logic [15:0] s, input bit we,
                         input logic [2:0] idx, input logic [15:0] val, input string tag);
        logic [15:0] exp;
        smp_valid = v; smp_in = s; coef_we = we; coef_idx = idx; coef_val = val;
        @(negedge clk);
        smp_valid = 1'b0; coef_we = 1'b0;
        if (v) begin
            exp = model_result();
            for (int k = 7; k > 0; k--) m_hist[k] = m_hist[k-1];
            m_hist[0] = s;
            m_last = exp;
        end
        if (we) m_coef[idx] = val;
        check(res_valid == v, {tag, " R3 valid"}, res_valid, v);
        check(res_out == m_last, {tag, " value"}, res_out, m_last);
    endtask

    task automatic sample(input logic [15:0] s, input string tag);
        cycle(1'b1, s, 1'b0, 3'd0, 16'h0, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cycle(1'b0, 16'h0, 1'b0, 3'd0, 16'h0, tag);
    endtask

    task automatic wcoef(input logic [2:0] idx, input logic [15:0] val, input string tag);
        cycle(1'b0, 16'h0, 1'b1, idx, val, tag);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R2: identity after reset, positive and negative samples
        sample(16'h4000, "R2 first");
        sample(16'hC001, "R2 pos");
        check(res_out == 16'd16383, "R2 floor pos", res_out, 16383);
        sample(16'h1234, "R2 neg");
        check(res_out == 16'hC001, "R2 floor neg", res_out, 16'hC001);
        sample(16'h0000, "R2 last");

        // R6: idle gaps do not shift the history
        idle(5, "R6 gap");
        sample(16'h7FFF, "R6 after gap");
        check(res_out == 16'h0000, "R6 history kept", res_out, 0);

        // R5, R7: write tap 1 while idle, history untouched
        wcoef(3'd1, 16'h4000, "R5 write tap1");
        sample(16'h0100, "R7 after write");
        // R7: write in the same cycle as a sample, used from the next one
        cycle(1'b1, 16'h0200, 1'b1, 3'd2, 16'h2000, "R7 same cycle");
        sample(16'h0300, "R7 next uses new");

        // R10: reset mid-stream clears history and weights
        do_reset();
        sample(16'h5555, "R10 first after reset");
        check(res_out == 16'h0000, "R10 cleared", res_out, 0);
        sample(16'h1111, "R10 second");

        // R8: step response with all taps at 1/8
        do_reset();
        for (int k = 0; k < 8; k++) wcoef(3'(k), 16'h1000, "R8 load");
        for (int i = 0; i < 12; i++) begin
            sample(16'h4000, "R8 step");
            check(res_out == 16'(2048 * ((i < 8) ? i : 8)), "R8 ramp",
                  res_out, 2048 * ((i < 8) ? i : 8));
        end

        // R4: wrap at full scale, both signs
        for (int k = 0; k < 8; k++) wcoef(3'(k), 16'h7FFF, "R4 load max");
        for (int i = 0; i < 9; i++) sample(16'h7FFF, "R4 wrap pos");
        for (int k = 0; k < 8; k++) wcoef(3'(k), 16'h8000, "R4 load min");
        for (int i = 0; i < 9; i++) sample(16'h8000, "R4 wrap min");
        for (int i = 0; i < 9; i++) sample(16'h7FFF, "R4 wrap mixed");

        // R4, R5, R6, R9: random mix
        for (int i = 0; i < 400; i++) begin
            int r = $urandom_range(0, 9);
            if (r < 2) begin
                wcoef(3'($urandom_range(0, 7)), 16'($urandom()), "R5 rand write");
            end else if (r < 3) begin
                idle(1, "R9 rand idle");
            end else if (r < 4) begin
                cycle(1'b1, 16'($urandom()), 1'b1, 3'($urandom_range(0, 7)),
                      16'($urandom()), "R7 rand both");
            end else begin
                sample(16'($urandom()), "R4 rand sample");
            end
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule